// File: doc/BRIEF.md
# ADC Output Code Formatter

This block takes a signed conversion result that has already been scaled so that one LSB equals one output code step. It produces the final data word together with two status flags. The result carries two integer bits more than the data word, so values up to about four times the nominal span can pass through. A select input picks one of two ranges. The bipolar range is symmetric about zero and uses offset binary. The unipolar range runs from zero to full scale and uses straight binary.

When clamping is off, a result above the nominal range wraps modulo the data width. A bipolar result below the range also wraps. The sign flag and the overrange flag then let downstream logic rebuild the true value. When clamping is on, an out-of-range result saturates to all ones or all zeros. Both flags are computed the same way in either case, from the result value alone.

A valid strobe is given with each result. One clock later the word and the flags are registered, and a one-cycle output valid pulse goes with them. Between strobes the outputs hold their last value.

Top module: `adc_code_formatter`

## Requirements
- R1: In bipolar mode (bipolar_i=1), an input v with -2^(W-1) <= v <= 2^(W-1)-1 gives data = v + 2^(W-1) and ovr=0. Here W is DATA_W. For W=16, 0 gives 0x8000, 32767 gives 0xFFFF and -32768 gives 0x0000 with sign=1.
- R2: In bipolar mode with clamp_i=0, an input above 2^(W-1)-1 gives data = (v + 2^(W-1)) mod 2^W, with ovr=1 and sign=0. For W=16, 32768 gives 0x0000, 32769 gives 0x0001 and 38011 gives 0x147B.
- R3: In bipolar mode with clamp_i=0, an input below -2^(W-1) gives data = (v + 2^(W-1)) mod 2^W, with ovr=1 and sign=1. For W=16, -32769 gives 0xFFFF, -32770 gives 0xFFFE and -38011 gives 0xEB85.
- R4: In unipolar mode (bipolar_i=0), an input v with 0 <= v <= 2^W-1 gives data = v, with sign=0 and ovr=0.
- R5: In unipolar mode with clamp_i=0, an input above 2^W-1 gives data = v mod 2^W, with ovr=1 and sign=0. For W=16, 65536 gives 0x0000 and 65537 gives 0x0001.
- R6: In unipolar mode, any negative input gives data = 0, sign=1 and ovr=1. This holds whether clamping is on or off.
- R7: With clamp_i=1, an input above the selected range gives data of all ones and an input below it gives all zeros. An in-range input gives the same word as with clamp_i=0.
- R8: sign is 1 exactly when the input is negative, and ovr is 1 exactly when the input lies outside the selected range. clamp_i has no effect on either flag.
- R9: data, sign and ovr change only on the clock edge that samples in_valid_i=1. out_valid_o is high for exactly the cycle after each strobe. Between strobes the outputs hold.
- R10: While rst_ni is low, out_valid_o, data_o, sign_o and ovr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Strobe marking a new result on raw_i |
| raw_i | input | DATA_W+2 | Signed scaled conversion result |
| bipolar_i | input | 1 | 1 selects the bipolar range, 0 the unipolar range |
| clamp_i | input | 1 | 1 saturates out-of-range results |
| out_valid_o | output | 1 | One-cycle pulse with each new output |
| data_o | output | DATA_W | Output data word |
| sign_o | output | 1 | Result was negative |
| ovr_o | output | 1 | Result was outside the nominal range |

## Verification
Every output is one register away from the inputs. A wrong range decision therefore shows in the very next cycle, as an ovr flag that disagrees with the input or as a word that wraps where it should saturate. Off-by-one limits show only at the exact range edges and one step past them. For this reason the directed cases sit on each edge and its neighbours in both ranges. A broken hold path shows one cycle after a strobe ends, as a word that moves while out_valid_o is low.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  // Range decision for one result
  typedef struct packed {
    logic neg;    // result below zero
    logic above;  // result above the selected range
    logic below;  // result below the selected range
  } range_t;
endpackage

// File: rtl/adcfmt_range.sv
module adcfmt_range
  import adcfmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W+1:0] raw_i,
  input  logic                     bipolar_i,
  output range_t                   flags_o
);
  localparam int IN_W = DATA_W + 2;
  localparam logic signed [IN_W-1:0] BIP_HI = {3'b000, {(DATA_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] BIP_LO = {3'b111, {(DATA_W-1){1'b0}}};
  localparam logic signed [IN_W-1:0] UNI_HI = {2'b00, {DATA_W{1'b1}}};
  localparam logic signed [IN_W-1:0] UNI_LO = '0;

  function automatic range_t classify(logic signed [IN_W-1:0] v, logic bip);
    range_t r;
    logic signed [IN_W-1:0] hi;
    logic signed [IN_W-1:0] lo;
    hi      = bip ? BIP_HI : UNI_HI;
    lo      = bip ? BIP_LO : UNI_LO;
    r.neg   = (v < UNI_LO);
    r.above = (v > hi);
    r.below = (v < lo);
    return r;
  endfunction

  always_comb flags_o = classify(raw_i, bipolar_i);
endmodule

// File: rtl/adcfmt_map.sv
module adcfmt_map #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W+1:0]  raw_i,
  input  logic               bipolar_i,
  input  logic               clamp_i,
  input  logic               above_i,
  input  logic               below_i,
  output logic [DATA_W-1:0]  code_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ALL_ZERO = '0;

  logic [1:0] unused_top;
  assign unused_top = raw_i[DATA_W+1:DATA_W];

  // Modulo-2^W wrap; bipolar uses offset binary (MSB inverted)
  function automatic logic [DATA_W-1:0] wrap_code(logic [DATA_W-1:0] low, logic bip);
    return bip ? {~low[DATA_W-1], low[DATA_W-2:0]} : low;
  endfunction

  always_comb begin
    if (clamp_i && above_i)
      code_o = ALL_ONES;
    else if (below_i && (clamp_i || !bipolar_i))
      code_o = ALL_ZERO;
    else
      code_o = wrap_code(raw_i[DATA_W-1:0], bipolar_i);
  end
endmodule

// File: rtl/adcfmt_stage.sv
module adcfmt_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              sign_i,
  input  logic              ovr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] code_o,
  output logic              sign_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      sign_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        code_o <= code_i;
        sign_o <= sign_i;
        ovr_o  <= ovr_i;
      end
    end
  end

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(code_o) && $stable(sign_o) && $stable(ovr_o)));
endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter
  import adcfmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W+1:0] raw_i,
  input  logic                     bipolar_i,
  input  logic                     clamp_i,
  output logic                     out_valid_o,
  output logic [DATA_W-1:0]        data_o,
  output logic                     sign_o,
  output logic                     ovr_o
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  range_t             flags;
  logic [DATA_W-1:0]  next_code;
  logic               next_ovr;

  adcfmt_range #(.DATA_W(DATA_W)) u_range (
    .raw_i     (raw_i),
    .bipolar_i (bipolar_i),
    .flags_o   (flags)
  );

  adcfmt_map #(.DATA_W(DATA_W)) u_map (
    .raw_i     (raw_i),
    .bipolar_i (bipolar_i),
    .clamp_i   (clamp_i),
    .above_i   (flags.above),
    .below_i   (flags.below),
    .code_o    (next_code)
  );

  assign next_ovr = flags.above | flags.below;

  adcfmt_stage #(.DATA_W(DATA_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .code_i  (next_code),
    .sign_i  (flags.neg),
    .ovr_i   (next_ovr),
    .valid_o (out_valid_o),
    .code_o  (data_o),
    .sign_o  (sign_o),
    .ovr_o   (ovr_o)
  );

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags.above && flags.below));
  p_mid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && bipolar_i && raw_i == '0) |=> (data_o == MID_CODE && !ovr_o && !sign_o));
  p_clamp_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && clamp_i && flags.above) |=> (data_o == '1 && ovr_o));
  p_clamp_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && clamp_i && flags.below) |=> (data_o == '0 && ovr_o));
  p_uni_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !bipolar_i && raw_i[DATA_W+1]) |=> (data_o == '0 && sign_o && ovr_o));
  p_over_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !clamp_i && flags.above) |=> (ovr_o && !sign_o));
endmodule

// File: tb/test_adc_code_formatter.sv
module test_adc_code_formatter;
  localparam int  DW     = 16;
  localparam time T_CLK  = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic signed [DW+1:0] raw = '0;
  logic bip = 1'b0;
  logic clp = 1'b0;
  logic vout;
  logic [DW-1:0] data;
  logic sign, ovr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(T_CLK/2) clk = ~clk;

  adc_code_formatter #(.DATA_W(DW)) i_adc_code_formatter (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vin), .raw_i(raw),
    .bipolar_i(bip), .clamp_i(clp), .out_valid_o(vout),
    .data_o(data), .sign_o(sign), .ovr_o(ovr)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model: integer range limits and modulo arithmetic
  task automatic run_case(string req, bit b, bit c, longint v);
    longint mask, lo, hi, ecode;
    bit es, eo;
    logic [DW-1:0] held;
    mask = (longint'(1) << DW) - 1;
    lo = b ? -(longint'(1) << (DW-1)) : 0;
    hi = b ? (longint'(1) << (DW-1)) - 1 : mask;
    es = (v < 0);
    eo = (v > hi) || (v < lo);
    if (c && v > hi) ecode = mask;
    else if (v < lo && (c || !b)) ecode = 0;
    else if (b) ecode = (v + (longint'(1) << (DW-1))) & mask;
    else ecode = v & mask;
    @(negedge clk);
    raw = v[DW+1:0]; bip = b; clp = c; vin = 1'b1;
    @(negedge clk);
    vin = 1'b0;
    check({req, " valid"}, vout, 1);
    check({req, " data"}, data, ecode);
    check({req, " sign"}, sign, es);
    check({req, " ovr"}, ovr, eo);
    held = data;
    raw = ~raw; bip = ~b; clp = ~c;
    @(negedge clk);
    check("R9 hold valid", vout, 0);
    check("R9 hold data", data, held);
  endtask

  task automatic test_reset();
    check("R10 valid", vout, 0);
    check("R10 data", data, 0);
    check("R10 sign", sign, 0);
    check("R10 ovr", ovr, 0);
  endtask

  task automatic test_bipolar_in();
    run_case("R1 zero", 1, 0, 0);
    run_case("R1 +fs", 1, 0, 32767);
    run_case("R1 -fs", 1, 0, -32768);
    run_case("R1 -1", 1, 0, -1);
  endtask

  task automatic test_bipolar_over();
    run_case("R2 +1", 1, 0, 32768);
    run_case("R2 +2", 1, 0, 32769);
    run_case("R2 116", 1, 0, 38011);
    run_case("R2 max", 1, 0, 131071);
  endtask

  task automatic test_bipolar_under();
    run_case("R3 -1", 1, 0, -32769);
    run_case("R3 -2", 1, 0, -32770);
    run_case("R3 116", 1, 0, -38011);
    run_case("R3 min", 1, 0, -131072);
  endtask

  task automatic test_unipolar();
    run_case("R4 zero", 0, 0, 0);
    run_case("R4 fs", 0, 0, 65535);
    run_case("R4 mid", 0, 0, 12345);
    run_case("R5 +1", 0, 0, 65536);
    run_case("R5 +2", 0, 0, 65537);
    run_case("R6 -1", 0, 0, -1);
    run_case("R6 -big", 0, 0, -70000);
    run_case("R6 clamp", 0, 1, -5);
  endtask

  task automatic test_clamp();
    run_case("R7 bip hi", 1, 1, 32768);
    run_case("R7 bip lo", 1, 1, -32769);
    run_case("R7 bip in", 1, 1, 32767);
    run_case("R7 uni hi", 0, 1, 65536);
    run_case("R8 bip -fs", 1, 1, -32768);
    run_case("R8 uni fs", 0, 1, 65535);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_bipolar_in();
    test_bipolar_over();
    test_bipolar_under();
    test_unipolar();
    test_clamp();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule